// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects up to eight level-sensitive interrupt requests from peripherals and presents a single interrupt line to a processor. Each request line passes through a per-line mask. The block picks the most urgent unmasked line and compares it with the most urgent level the processor is already servicing. The interrupt line is raised only when the candidate would preempt the current service, or when nothing is in service.

The processor answers with an acknowledge pulse. On that pulse the block marks the chosen line as in service and returns a byte that identifies the source. The byte is a programmable five-bit base in the upper bits and the three-bit line number in the lower bits. A request at the same or a lower level than the active service is held back until software closes the service with an end-of-service command. A more urgent request may nest on top of the active service.

A small host port gives access to the block. It has an 8-bit write bus, an 8-bit registered read bus, a chip select, read and write strobes and one address bit. Through it software sets the mask, loads the vector base, reads the in-service set and issues the end-of-service command.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 8'hFF, the in-service set reads 8'h00, `rdata` is 8'h00 and `int_o` is low.
- R2: An unmasked request that rises before a clock edge, with nothing in service, drives `int_o` high right after that edge.
- R3: A write with `addr`=1 loads the mask from `wdata`, where bit i set blocks line i. A read with `addr`=1 returns the mask. A masked line never raises `int_o`.
- R4: Line 0 is the most urgent and line 7 the least. The clock edge that samples `inta` high with `int_o` high loads `rdata` with {base, index of the most urgent eligible line}.
- R5: That acknowledge sets the in-service bit of the chosen line. A read with `addr`=0 returns the in-service set, bit i for line i.
- R6: While a line is in service, requests from that line or from less urgent lines keep `int_o` low. They raise `int_o` once the service is closed.
- R7: A request more urgent than the most urgent in-service line raises `int_o` and can be acknowledged while the earlier service stays set.
- R8: A write with `addr`=0 and `wdata[0]`=1 is the end-of-service command. It clears only the most urgent set in-service bit.
- R9: A write with `addr`=0 and `wdata[0]`=0 loads the vector base from `wdata[7:3]`.
- R10: Requests are level-sensitive. A line dropped before acknowledge is forgotten, and `int_o` falls right after the edge that samples it low.
- R11: An acknowledge while `int_o` is low returns {base, 3'b111} and leaves the in-service set unchanged.
- R12: Strobes with `cs` low change no register and no read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Host chip select, active high |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| addr | input | 1 | Register select: 0 command/in-service, 1 mask |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data and acknowledge vector |
| irq_in | input | 8 | Level request lines, bit 0 most urgent |
| inta | input | 1 | Interrupt acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bench first drives single requests to show the basic raise, mask and vector paths. It then drives two requests at once on lines 2 and 4 to tell fixed priority apart from arrival order. A more urgent request on line 1 is added during a service to separate nesting from deferral. A request on the line already in service tells the equal-level hold apart from a plain less-urgent hold. Dropping a line before acknowledge and acknowledging with nothing pending separate level-sensitive behaviour from latched behaviour and from a blind in-service update.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      HOST_IDLE,
      HOST_CMD_WR,
      HOST_MASK_WR,
      HOST_READ
   } host_op_e;

   function automatic host_op_e decode_host(input logic cs, input logic rd,
                                            input logic wr, input logic addr);
      host_op_e op;
      op = HOST_IDLE;
      if (cs && wr)      op = addr ? HOST_MASK_WR : HOST_CMD_WR;
      else if (cs && rd) op = HOST_READ;
      return op;
   endfunction

endpackage

// File: rtl/pic_req_sync.sv
module pic_req_sync #(
   parameter int N_IRQ  = 8,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   output logic [N_IRQ-1:0] irr
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("pic_req_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [N_IRQ-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= irq_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign irr = stage_q[STAGES-1];

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int N    = 8,
   parameter int ID_W = 3
) (
   input  logic [N-1:0]    req,
   output logic            valid,
   output logic [ID_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = ID_W'(i);
      end
      valid = |req;
   end

endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
   parameter int N_IRQ = 8,
   parameter int ID_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [ID_W-1:0]  set_idx,
   input  logic             clr_en,
   output logic [N_IRQ-1:0] isr,
   output logic             top_valid,
   output logic [ID_W-1:0]  top_idx
);

   logic [N_IRQ-1:0] isr_q, isr_d, set_mask, clr_mask;

   pic_prio_enc #(.N(N_IRQ), .ID_W(ID_W)) i_top_enc (
      .req   (isr_q),
      .valid (top_valid),
      .idx   (top_idx)
   );

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (set_en)              set_mask[set_idx] = 1'b1;
      if (clr_en && top_valid) clr_mask[top_idx] = 1'b1;
      isr_d = (isr_q & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   assign isr = isr_q;

   p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> isr_q[$past(set_idx)]);

   p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && isr_q != '0) |=>
         ($countones(isr_q) + 1 == $countones($past(isr_q))));

   p_nest_higher_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && top_valid) |-> (set_idx < top_idx));

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
   parameter int N_IRQ      = 8,
   parameter int DATA_W     = 8,
   parameter int REQ_STAGES = 1,
   parameter int RESET_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              inta,
   output logic              int_o
);
   import pic_pkg::*;

   localparam int ID_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
   localparam int BASE_W = DATA_W - ID_W;

   generate
      if (N_IRQ < 2 || N_IRQ > DATA_W) begin : g_bad_n
         $error("pic_ctrl: N_IRQ must lie in 2..DATA_W");
      end
      if (BASE_W < 1) begin : g_bad_w
         $error("pic_ctrl: DATA_W too narrow for a vector base");
      end
   endgenerate

   logic [N_IRQ-1:0]  irr, mask_q, eligible, isr;
   logic [BASE_W-1:0] base_q;
   logic [DATA_W-1:0] rdata_q;
   logic              win_valid, top_valid, int_want, ack_take, eoi;
   logic [ID_W-1:0]   win_idx, top_idx;
   host_op_e          op;

   pic_req_sync #(.N_IRQ(N_IRQ), .STAGES(REQ_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .irr    (irr)
   );

   assign eligible = irr & ~mask_q;

   pic_prio_enc #(.N(N_IRQ), .ID_W(ID_W)) i_win_enc (
      .req   (eligible),
      .valid (win_valid),
      .idx   (win_idx)
   );

   assign op       = decode_host(cs, rd, wr, addr);
   assign eoi      = (op == HOST_CMD_WR) && wdata[0];
   assign int_want = win_valid && (!top_valid || (win_idx < top_idx));
   assign ack_take = inta && int_want;

   pic_isr #(.N_IRQ(N_IRQ), .ID_W(ID_W)) i_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (ack_take),
      .set_idx   (win_idx),
      .clr_en    (eoi),
      .isr       (isr),
      .top_valid (top_valid),
      .top_idx   (top_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         base_q <= BASE_W'(RESET_BASE);
      end else begin
         if (op == HOST_MASK_WR)           mask_q <= wdata[N_IRQ-1:0];
         if (op == HOST_CMD_WR && !wdata[0]) base_q <= wdata[DATA_W-1:ID_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (inta) begin
         rdata_q <= ack_take ? {base_q, win_idx} : {base_q, {ID_W{1'b1}}};
      end else if (op == HOST_READ) begin
         rdata_q <= addr ? DATA_W'(mask_q) : DATA_W'(isr);
      end
   end

   assign rdata = rdata_q;
   assign int_o = int_want;

   p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((irr & ~mask_q) != '0));

   p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> (rdata[ID_W-1:0] == $past(win_idx)));

   p_no_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> ($stable(mask_q) && $stable(base_q)));

endmodule

// File: tb/test_pic_ctrl.sv
`timescale 1ns/1ps
module test_pic_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 0, rd = 0, wr = 0, addr = 0, inta = 0;
   logic [7:0] wdata = '0, irq_in = '0;
   logic [7:0] rdata;
   logic       int_o;

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       look = 1'b0;

   always #2.5 clk = ~clk;

   pic_ctrl i_pic_ctrl (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .inta(inta), .int_o(int_o)
   );

   // monitor: compares registered read data against the scoreboard queue
   always @(negedge clk) begin
      if (look) begin
         look = 1'b0;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_errors++;
            $display("FAIL %s: rdata 0x%02h with empty scoreboard (expected none)", "monitor", rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               n_errors++;
               $display("FAIL %s: rdata 0x%02h expected 0x%02h", t, rdata, e);
            end
         end
      end
   end

   task automatic check_int(input logic e, input string t);
      n_checks++;
      if (int_o !== e) begin
         n_errors++;
         $display("FAIL %s: int_o %0b expected %0b", t, int_o, e);
      end
   endtask

   task automatic do_write(input logic a, input logic [7:0] d, input logic sel);
      @(negedge clk);
      cs = sel; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 0; wr = 0;
   endtask

   task automatic do_read(input logic a, input logic [7:0] e, input string t, input logic sel);
      @(negedge clk);
      cs = sel; rd = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk);
      #1 look = 1'b1;
      @(negedge clk);
      cs = 0; rd = 0;
   endtask

   task automatic do_ack(input logic [7:0] e, input string t);
      @(negedge clk);
      inta = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk);
      #1 look = 1'b1;
      @(negedge clk);
      inta = 1'b0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_int(1'b0, "R1 int after reset");
      n_checks++;
      if (rdata !== 8'h00) begin
         n_errors++;
         $display("FAIL R1: rdata 0x%02h expected 0x00", rdata);
      end
      rst_n = 1'b1;
      do_read(1'b1, 8'hFF, "R1 mask reset", 1'b1);
      do_read(1'b0, 8'h00, "R1 isr reset", 1'b1);

      do_write(1'b1, 8'h00, 1'b0);
      do_read(1'b1, 8'hFF, "R12 mask write without cs", 1'b1);

      set_irq(8'h10);
      check_int(1'b0, "R3 masked request");
      do_write(1'b1, 8'h00, 1'b1);
      do_read(1'b1, 8'h00, "R3 mask readback", 1'b1);
      check_int(1'b1, "R3 unmasked request raises");
      set_irq(8'h00);
      check_int(1'b0, "R10 request dropped");
      set_irq(8'h10);
      check_int(1'b1, "R2 request raises int");

      do_write(1'b0, 8'hA8, 1'b1);
      set_irq(8'h14);
      do_ack(8'hAA, "R4 vector for line 2 over line 4");
      check_int(1'b0, "R6 line 4 held while line 2 served");
      do_read(1'b0, 8'h04, "R5 isr after ack", 1'b1);

      set_irq(8'h16);
      check_int(1'b1, "R7 line 1 nests over line 2");
      do_ack(8'hA9, "R7 vector for line 1");
      do_read(1'b0, 8'h06, "R7 both lines in service", 1'b1);

      do_write(1'b0, 8'h01, 1'b1);
      do_read(1'b0, 8'h04, "R8 eoi clears line 1 only", 1'b1);
      check_int(1'b1, "R8 line 1 still asserted again above line 2");
      set_irq(8'h14);
      check_int(1'b0, "R10 line 1 withdrawn");
      do_write(1'b0, 8'h01, 1'b1);
      check_int(1'b1, "R6 pending line raises after eoi");

      set_irq(8'h10);
      do_ack(8'hAC, "R9 base 0x15 with line 4");
      check_int(1'b0, "R6 equal line held");
      do_write(1'b0, 8'h01, 1'b1);
      check_int(1'b1, "R6 equal line raises after eoi");
      set_irq(8'h00);
      check_int(1'b0, "R10 all dropped");
      do_ack(8'hAF, "R11 acknowledge with nothing pending");
      do_read(1'b0, 8'h00, "R11 isr unchanged", 1'b1);

      do_write(1'b0, 8'h50, 1'b0);
      set_irq(8'h01);
      do_ack(8'hA8, "R12 base unchanged without cs");
      do_write(1'b1, 8'h01, 1'b1);
      do_write(1'b0, 8'h01, 1'b1);
      check_int(1'b0, "R3 line 0 masked");
      do_read(1'b0, 8'h00, "R8 eoi cleared line 0", 1'b1);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run not finished (expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule